// File: doc/BRIEF.md
# Deferred Status Flag Unit

This unit holds the arithmetic and control status flags of an 8/16-bit processor datapath without computing the arithmetic flags after every ALU operation. When the ALU strobes an update, the unit saves a snapshot: the operation class, the destination and source operands, the result and the operand width. Carry, parity, auxiliary carry, zero, sign and overflow are then derived combinationally from that snapshot whenever they are read. Shifts and rotates get their carry from the saved count. Increment and decrement take a cheaper overflow test. A pop-style restore loads a 16-bit word, and the flags are then read straight from its bit positions.

The stored operation class is the unit's state. The states are EAGER, ADD, SUB, INC, DEC, SHL, SHR, SAR, ROL, ROR and LOADED. The named transitions are as follows. Reset enters EAGER. A flag-word load enters LOADED from any state. An update strobe enters the state named by its operation code from any state. With neither strobe the unit stays in its present state. The trap, interrupt-enable and direction bits sit apart from the snapshot. They change only on a direct write or on a flag-word load.

Top module: `lf_flags`

## Requirements
- R1: After reset the unit is in EAGER with all six arithmetic flags and trap, interrupt-enable and direction at 0, so `flags_word` reads 16'hF02A.
- R2: `flags_word` carries carry at bit 0, parity at 2, auxiliary carry at 4, zero at 6, sign at 7, trap at 8, interrupt enable at 9, direction at 10 and overflow at 11. Bits 15:12, 1, 3 and 5 always read 1.
- R3: `upd_word`=1 selects 16-bit width with sign mask 16'h8000, and 0 selects byte width with sign mask 16'h0080. For byte updates the upper byte of operands and result is ignored. For all classes except EAGER, ROL and ROR: sign is the result bit under the mask, zero is set when the width-masked result is 0, and parity is set when the masked result has an even number of ones.
- R4: Operation codes are EAGER=0, ADD=1, SUB=2, INC=3, DEC=4, SHL=5, SHR=6, SAR=7, ROL=8 and ROR=9. Codes 10 to 15 act as EAGER. For ADD and SUB, carry is the captured `upd_eflags[0]` and auxiliary carry is bit 4 of dst^src^res. SUB overflow is the masked (src^dst)&(dst^res). ADD overflow is the masked ~(src^dst)&(dst^res).
- R5: For INC, overflow is set exactly when the masked result equals the sign mask. For DEC, it is set exactly when the masked result equals the sign mask minus 1. Both keep carry at the captured `upd_eflags[0]` and take auxiliary carry as in R4.
- R6: Shifts take the count n from the masked source. For SHR and SAR with 1<=n<=width, carry is dst bit n-1. For SHL, carry is dst ANDed with (sign mask >> (n-1)). When n is 0 or larger than the width, carry is 0 for SHL and SHR and is the dst sign bit for SAR.
- R7: Rotates use the rotate mask width-1, so k=(n-1)&mask computed in 16-bit wrap. ROR carry is dst bit k. ROL carry is dst ANDed with (sign mask >> k). Parity, auxiliary carry, zero and sign come from the captured `upd_eflags` bits 1, 2, 3 and 4.
- R8: For all shifts and rotates, overflow is the masked dst^res. Auxiliary carry after a shift reads 0.
- R9: A load (`ld_valid`) enters LOADED. Each arithmetic flag is then read from its R2 bit position in `ld_word`, and trap, interrupt enable and direction are latched from bits 8, 9 and 10.
- R10: `ctl_we[i]` writes `ctl_val[i]` into trap (i=0), interrupt enable (i=1) or direction (i=2), visible after the edge. It leaves the arithmetic flags unchanged and wins over a load in the same cycle for that bit.
- R11: When a load and an update strobe arrive in the same cycle, the load wins and the update is discarded.
- R12: In EAGER the six flags are `upd_eflags` bits 0 to 5 in the order carry, parity, auxiliary carry, zero, sign, overflow.
- R13: With no update, load or control write, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | ALU update strobe |
| upd_op | input | 4 | Operation class code |
| upd_dst | input | 16 | Destination operand before the operation |
| upd_src | input | 16 | Source operand or shift/rotate count |
| upd_res | input | 16 | ALU result |
| upd_word | input | 1 | 1 = 16-bit operation, 0 = byte |
| upd_eflags | input | 6 | Precomputed flags / captured carry and rotate flags |
| ld_valid | input | 1 | Flag-word load strobe |
| ld_word | input | 16 | Flag word to restore |
| ctl_we | input | 3 | Direct write enables: trap, interrupt enable, direction |
| ctl_val | input | 3 | Direct write values |
| cf | output | 1 | Carry |
| pf | output | 1 | Parity (even) |
| af | output | 1 | Auxiliary carry |
| zf | output | 1 | Zero |
| sf | output | 1 | Sign |
| of | output | 1 | Overflow |
| tf | output | 1 | Trap |
| ie | output | 1 | Interrupt enable |
| df | output | 1 | Direction |
| flags_word | output | 16 | Packed flag word |

## Verification
Two pairs of functions can land on the same clock edge: a flag-word load together with an ALU update strobe, and a load together with a direct control-bit write. The bench drives each pair on a single edge. It uses operands whose update result would give flags that differ from those in the loaded word. After that edge it checks two things: every arithmetic flag follows the loaded word, and any control bit with a write enable follows the written value, not the loaded bit.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int LF_DW = 16;
    localparam int LF_NARITH = 6;

    // arithmetic flag vector indices
    localparam int AI_CF = 0;
    localparam int AI_PF = 1;
    localparam int AI_AF = 2;
    localparam int AI_ZF = 3;
    localparam int AI_SF = 4;
    localparam int AI_OF = 5;

    // packed word bit positions
    localparam int WB_CF = 0;
    localparam int WB_PF = 2;
    localparam int WB_AF = 4;
    localparam int WB_ZF = 6;
    localparam int WB_SF = 7;
    localparam int WB_TF = 8;
    localparam int WB_IE = 9;
    localparam int WB_DF = 10;
    localparam int WB_OF = 11;

    localparam logic [15:0] WORD_FIXED = 16'hF02A;

    typedef enum logic [3:0] {
        M_EAGER  = 4'd0,
        M_ADD    = 4'd1,
        M_SUB    = 4'd2,
        M_INC    = 4'd3,
        M_DEC    = 4'd4,
        M_SHL    = 4'd5,
        M_SHR    = 4'd6,
        M_SAR    = 4'd7,
        M_ROL    = 4'd8,
        M_ROR    = 4'd9,
        M_LOADED = 4'd10
    } lf_mode_e;
endpackage

// File: rtl/lf_capture.sv
module lf_capture
    import lf_pkg::*;
#(
    parameter int DW = LF_DW,
    parameter int NA = LF_NARITH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [3:0]    upd_op,
    input  logic [DW-1:0] upd_dst,
    input  logic [DW-1:0] upd_src,
    input  logic [DW-1:0] upd_res,
    input  logic          upd_word,
    input  logic [NA-1:0] upd_eflags,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_word,
    output lf_mode_e      mode_q,
    output logic          word_q,
    output logic [DW-1:0] dst_q,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] res_q,
    output logic [NA-1:0] ef_q
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] BYTE_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    lf_mode_e      mode_d;
    logic          word_d;
    logic [DW-1:0] dst_d, src_d, res_d, wmask;
    logic [NA-1:0] ef_d;

    assign wmask = upd_word ? {DW{1'b1}} : BYTE_MASK;

    // next state
    always_comb begin
        mode_d = mode_q;
        word_d = word_q;
        dst_d  = dst_q;
        src_d  = src_q;
        res_d  = res_q;
        ef_d   = ef_q;
        if (ld_valid) begin
            mode_d = M_LOADED;
            word_d = 1'b1;
            dst_d  = '0;
            src_d  = '0;
            res_d  = ld_word;
            ef_d   = '0;
        end else if (upd_valid) begin
            unique case (upd_op)
                4'd1:    mode_d = M_ADD;
                4'd2:    mode_d = M_SUB;
                4'd3:    mode_d = M_INC;
                4'd4:    mode_d = M_DEC;
                4'd5:    mode_d = M_SHL;
                4'd6:    mode_d = M_SHR;
                4'd7:    mode_d = M_SAR;
                4'd8:    mode_d = M_ROL;
                4'd9:    mode_d = M_ROR;
                default: mode_d = M_EAGER;
            endcase
            word_d = upd_word;
            dst_d  = upd_dst & wmask;
            src_d  = upd_src & wmask;
            res_d  = upd_res & wmask;
            ef_d   = upd_eflags;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_EAGER;
            word_q <= 1'b1;
            dst_q  <= '0;
            src_q  <= '0;
            res_q  <= '0;
            ef_q   <= '0;
        end else begin
            mode_q <= mode_d;
            word_q <= word_d;
            dst_q  <= dst_d;
            src_q  <= src_d;
            res_q  <= res_d;
            ef_q   <= ef_d;
        end
    end
endmodule

// File: rtl/lf_shift_carry.sv
module lf_shift_carry
    import lf_pkg::*;
#(
    parameter int DW = LF_DW
) (
    input  lf_mode_e      mode,
    input  logic          word,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] sign_mask,
    output logic          carry
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] FULL_W = DW[DW-1:0];
    localparam logic [DW-1:0] HALF_W = HW[DW-1:0];

    logic [DW-1:0] width, rot_mask, nm1, rk, right_v, left_m, rot_r_v, rot_l_m;
    logic          in_range, sign_bit;

    assign width    = word ? FULL_W : HALF_W;
    assign rot_mask = width - 1'b1;
    assign nm1      = cnt - 1'b1;
    assign rk       = nm1 & rot_mask;
    assign in_range = (cnt != '0) && (cnt <= width);
    assign sign_bit = |(dst & sign_mask);
    assign right_v  = dst >> nm1;
    assign left_m   = sign_mask >> nm1;
    assign rot_r_v  = dst >> rk;
    assign rot_l_m  = sign_mask >> rk;

    always_comb begin
        unique case (mode)
            M_SHL:   carry = in_range ? |(dst & left_m) : 1'b0;
            M_SHR:   carry = in_range ? right_v[0] : 1'b0;
            M_SAR:   carry = in_range ? right_v[0] : sign_bit;
            M_ROL:   carry = |(dst & rot_l_m);
            M_ROR:   carry = rot_r_v[0];
            default: carry = 1'b0;
        endcase
    end
endmodule

// File: rtl/lf_eval.sv
module lf_eval
    import lf_pkg::*;
#(
    parameter int DW = LF_DW,
    parameter int NA = LF_NARITH
) (
    input  lf_mode_e      mode,
    input  logic          word,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] res,
    input  logic [NA-1:0] ef,
    input  logic          sh_carry,
    input  logic [DW-1:0] sign_mask,
    output logic [NA-1:0] flags
);
    logic [DW-1:0] aux_v;
    logic          par_even, zero_v, sign_v, add_af;
    logic          of_sub, of_add, of_sh;

    // parity tree built bit by bit
    logic [DW:0] par_chain;
    assign par_chain[0] = 1'b0;
    for (genvar i = 0; i < DW; i++) begin : g_par
        assign par_chain[i+1] = par_chain[i] ^ res[i];
    end

    assign par_even = ~par_chain[DW];
    assign zero_v   = (res == '0);
    assign sign_v   = |(res & sign_mask);
    assign aux_v    = dst ^ src ^ res;
    assign add_af   = aux_v[4];
    assign of_sub   = |(sign_mask & (src ^ dst) & (dst ^ res));
    assign of_add   = |(sign_mask & ~(src ^ dst) & (dst ^ res));
    assign of_sh    = |(sign_mask & (dst ^ res));

    // output process
    always_comb begin
        flags = '0;
        unique case (mode)
            M_EAGER: flags = ef;
            M_LOADED: begin
                flags[AI_CF] = res[WB_CF];
                flags[AI_PF] = res[WB_PF];
                flags[AI_AF] = res[WB_AF];
                flags[AI_ZF] = res[WB_ZF];
                flags[AI_SF] = res[WB_SF];
                flags[AI_OF] = res[WB_OF];
            end
            M_ADD, M_SUB, M_INC, M_DEC: begin
                flags[AI_CF] = ef[AI_CF];
                flags[AI_PF] = par_even;
                flags[AI_AF] = add_af;
                flags[AI_ZF] = zero_v;
                flags[AI_SF] = sign_v;
                unique case (mode)
                    M_ADD:   flags[AI_OF] = of_add;
                    M_SUB:   flags[AI_OF] = of_sub;
                    M_INC:   flags[AI_OF] = (res == sign_mask);
                    default: flags[AI_OF] = (res == (sign_mask - 1'b1));
                endcase
            end
            M_SHL, M_SHR, M_SAR: begin
                flags[AI_CF] = sh_carry;
                flags[AI_PF] = par_even;
                flags[AI_AF] = 1'b0;
                flags[AI_ZF] = zero_v;
                flags[AI_SF] = sign_v;
                flags[AI_OF] = of_sh;
            end
            M_ROL, M_ROR: begin
                flags[AI_CF] = sh_carry;
                flags[AI_PF] = ef[AI_PF];
                flags[AI_AF] = ef[AI_AF];
                flags[AI_ZF] = ef[AI_ZF];
                flags[AI_SF] = ef[AI_SF];
                flags[AI_OF] = of_sh;
            end
            default: flags = '0;
        endcase
    end
    wire unused_word = word;
endmodule

// File: rtl/lf_ctrl_bits.sv
module lf_ctrl_bits
    import lf_pkg::*;
#(
    parameter int NB = 3,
    parameter int BASE = WB_TF,
    parameter int DW = LF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] we,
    input  logic [NB-1:0] val,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_word,
    output logic [NB-1:0] q
);
    for (genvar i = 0; i < NB; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          q[i] <= 1'b0;
            else if (we[i])      q[i] <= val[i];
            else if (ld_valid)   q[i] <= ld_word[BASE+i];
        end
    end
endmodule

// File: rtl/lf_flags.sv
module lf_flags
    import lf_pkg::*;
#(
    parameter int DW = LF_DW,
    parameter int NA = LF_NARITH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_valid,
    input  logic [3:0]    upd_op,
    input  logic [DW-1:0] upd_dst,
    input  logic [DW-1:0] upd_src,
    input  logic [DW-1:0] upd_res,
    input  logic          upd_word,
    input  logic [NA-1:0] upd_eflags,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_word,
    input  logic [2:0]    ctl_we,
    input  logic [2:0]    ctl_val,
    output logic          cf,
    output logic          pf,
    output logic          af,
    output logic          zf,
    output logic          sf,
    output logic          of,
    output logic          tf,
    output logic          ie,
    output logic          df,
    output logic [DW-1:0] flags_word
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] SM_FULL = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] SM_HALF = {{(HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};

    lf_mode_e      mode_q;
    logic          word_q, sh_carry;
    logic [DW-1:0] dst_q, src_q, res_q, sign_mask;
    logic [NA-1:0] ef_q, flags;
    logic [2:0]    ctl_q;

    lf_capture #(.DW(DW), .NA(NA)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_dst(upd_dst),
        .upd_src(upd_src), .upd_res(upd_res), .upd_word(upd_word),
        .upd_eflags(upd_eflags), .ld_valid(ld_valid), .ld_word(ld_word),
        .mode_q(mode_q), .word_q(word_q), .dst_q(dst_q), .src_q(src_q),
        .res_q(res_q), .ef_q(ef_q)
    );

    assign sign_mask = word_q ? SM_FULL : SM_HALF;

    lf_shift_carry #(.DW(DW)) u_shc (
        .mode(mode_q), .word(word_q), .dst(dst_q), .cnt(src_q),
        .sign_mask(sign_mask), .carry(sh_carry)
    );

    lf_eval #(.DW(DW), .NA(NA)) u_eval (
        .mode(mode_q), .word(word_q), .dst(dst_q), .src(src_q), .res(res_q),
        .ef(ef_q), .sh_carry(sh_carry), .sign_mask(sign_mask), .flags(flags)
    );

    lf_ctrl_bits #(.NB(3), .BASE(WB_TF), .DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .val(ctl_val),
        .ld_valid(ld_valid), .ld_word(ld_word), .q(ctl_q)
    );

    assign cf = flags[AI_CF];
    assign pf = flags[AI_PF];
    assign af = flags[AI_AF];
    assign zf = flags[AI_ZF];
    assign sf = flags[AI_SF];
    assign of = flags[AI_OF];
    assign tf = ctl_q[0];
    assign ie = ctl_q[1];
    assign df = ctl_q[2];

    always_comb begin
        flags_word        = WORD_FIXED;
        flags_word[WB_CF] = cf;
        flags_word[WB_PF] = pf;
        flags_word[WB_AF] = af;
        flags_word[WB_ZF] = zf;
        flags_word[WB_SF] = sf;
        flags_word[WB_TF] = tf;
        flags_word[WB_IE] = ie;
        flags_word[WB_DF] = df;
        flags_word[WB_OF] = of;
    end
endmodule

// File: rtl/lf_flags_chk.sv
module lf_flags_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_valid,
    input logic [3:0]    upd_op,
    input logic [DW-1:0] upd_res,
    input logic          upd_word,
    input logic          ld_valid,
    input logic [DW-1:0] ld_word,
    input logic [2:0]    ctl_we,
    input logic [2:0]    ctl_val,
    input logic          cf,
    input logic          pf,
    input logic          zf,
    input logic          sf,
    input logic          of,
    input logic          tf,
    input logic          df,
    input logic [DW-1:0] flags_word
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] SMF = {1'b1, {(DW-1){1'b0}}};
    localparam logic [HW-1:0] SMH = {1'b1, {(HW-1){1'b0}}};

    p_load_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (cf == $past(ld_word[0])) && (pf == $past(ld_word[2]))
                  && (zf == $past(ld_word[6])) && (of == $past(ld_word[11])));

    p_load_over_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && upd_valid) |=> (sf == $past(ld_word[7])));

    p_inc_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !ld_valid && upd_op == 4'd3) |=>
        (of == ($past(upd_word) ? ($past(upd_res) == SMF)
                                : ($past(upd_res[HW-1:0]) == SMH))));

    p_zero_arith_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !ld_valid && upd_op >= 4'd1 && upd_op <= 4'd7) |=>
        (zf == ($past(upd_word) ? ($past(upd_res) == '0)
                                : ($past(upd_res[HW-1:0]) == '0))));

    p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we[0] |=> (tf == $past(ctl_val[0])));

    p_ctl_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we[2] |=> (df == $past(ctl_val[2])));

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !ld_valid && ctl_we == 3'b000) |=> $stable(flags_word));
endmodule

bind lf_flags lf_flags_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_op(upd_op),
    .upd_res(upd_res), .upd_word(upd_word), .ld_valid(ld_valid),
    .ld_word(ld_word), .ctl_we(ctl_we), .ctl_val(ctl_val),
    .cf(cf), .pf(pf), .zf(zf), .sf(sf), .of(of), .tf(tf), .df(df),
    .flags_word(flags_word)
);

// File: tb/lf_flags_test.sv
module lf_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [3:0]  upd_op = 4'd0;
    logic [15:0] upd_dst = '0, upd_src = '0, upd_res = '0;
    logic        upd_word = 1'b0;
    logic [5:0]  upd_eflags = '0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_word = '0;
    logic [2:0]  ctl_we = '0, ctl_val = '0;
    logic cf, pf, af, zf, sf, of, tf, ie, df;
    logic [15:0] flags_word;

    int checks = 0;
    int fails = 0;
    logic [2:0] exp_ctl = '0;

    always #10 clk = ~clk;

    lf_flags uut (.*);

    function automatic logic [5:0] ref_flags(int op, logic [15:0] d0, logic [15:0] s0,
                                             logic [15:0] r0, logic w, logic [5:0] e);
        logic [15:0] mk, sm, d, s, r;
        int W, n, k;
        logic c, p, a, z, sg, o;
        mk = w ? 16'hFFFF : 16'h00FF;
        sm = w ? 16'h8000 : 16'h0080;
        W  = w ? 16 : 8;
        d = d0 & mk; s = s0 & mk; r = r0 & mk;
        p = 1'b1;
        for (int i = 0; i < 16; i++) if (r[i]) p = ~p;
        z = (r == 0); sg = |(r & sm);
        a = 1'b0; c = 1'b0; o = 1'b0;
        n = int'(s);
        k = (n - 1) & (W - 1);
        if (op < 1 || op > 9) return e;
        case (op)
            1: begin c = e[0]; a = d[4]^s[4]^r[4]; o = |(sm & ~(d^s) & (d^r)); end
            2: begin c = e[0]; a = d[4]^s[4]^r[4]; o = |(sm & (d^s) & (d^r)); end
            3: begin c = e[0]; a = d[4]^s[4]^r[4]; o = (r == sm); end
            4: begin c = e[0]; a = d[4]^s[4]^r[4]; o = (r == sm - 16'd1); end
            5: begin c = (n >= 1 && n <= W) ? |(d & (sm >> (n-1))) : 1'b0; o = |(sm&(d^r)); end
            6: begin c = (n >= 1 && n <= W) ? d[n-1] : 1'b0; o = |(sm&(d^r)); end
            7: begin c = (n >= 1 && n <= W) ? d[n-1] : |(d & sm); o = |(sm&(d^r)); end
            8: begin c = |(d & (sm >> k)); o = |(sm&(d^r)); p=e[1]; a=e[2]; z=e[3]; sg=e[4]; end
            default: begin c = d[k]; o = |(sm&(d^r)); p=e[1]; a=e[2]; z=e[3]; sg=e[4]; end
        endcase
        return {o, sg, z, a, p, c};
    endfunction

    function automatic logic [15:0] pack(logic [5:0] f, logic [2:0] ct);
        return 16'hF02A | {4'h0, f[5], ct, f[4], f[3], 1'b0, f[2], 1'b0, f[1], 1'b0, f[0]};
    endfunction

    task automatic check(string req, logic [5:0] ef);
        logic [5:0] act;
        logic [15:0] ew;
        act = {of, sf, zf, af, pf, cf};
        ew = pack(ef, exp_ctl);
        checks++;
        if (act !== ef || flags_word !== ew || {df, ie, tf} !== exp_ctl) begin
            fails++;
            $display("FAIL %s: flags=%b word=%h ctl=%b expected flags=%b word=%h ctl=%b",
                     req, act, flags_word, {df, ie, tf}, ef, ew, exp_ctl);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0; ld_valid = 1'b0; ctl_we = '0;
    endtask

    task automatic upd(string req, int op, logic [15:0] d, logic [15:0] s,
                       logic [15:0] r, logic w, logic [5:0] e);
        upd_valid = 1'b1; upd_op = op[3:0]; upd_dst = d; upd_src = s;
        upd_res = r; upd_word = w; upd_eflags = e;
        step();
        check(req, ref_flags(op, d, s, r, w, e));
    endtask

    task automatic t_reset();
        check("R1 reset", 6'b0);
        checks++;
        if (flags_word !== 16'hF02A) begin
            fails++; $display("FAIL R1 word=%h expected F02A", flags_word);
        end
    endtask

    task automatic t_eager();
        upd("R12 eager", 0, 16'h1234, 0, 0, 1'b1, 6'b101011);
        upd("R12 eager code 13", 13, 0, 0, 0, 1'b0, 6'b010100);
        upd("R2 eager all set", 0, 0, 0, 0, 1'b1, 6'b111111);
    endtask

    task automatic t_arith();
        upd("R4 add byte overflow", 1, 16'h007F, 16'h0001, 16'h0080, 1'b0, 6'b0);
        upd("R4 sub word overflow", 2, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 6'b000001);
        upd("R4 sub borrow", 2, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 6'b000001);
        upd("R3 byte upper ignored zero", 1, 16'hAB80, 16'hCD80, 16'h5A00, 1'b0, 6'b000001);
        upd("R3 word parity odd", 1, 16'h0000, 16'h0007, 16'h0007, 1'b1, 6'b0);
        upd("R5 inc byte boundary", 3, 16'h007F, 16'h0001, 16'h0080, 1'b0, 6'b000001);
        upd("R5 inc word boundary", 3, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 6'b0);
        upd("R5 inc no overflow", 3, 16'h0080, 16'h0001, 16'h0081, 1'b1, 6'b0);
        upd("R5 dec word boundary", 4, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 6'b000001);
        upd("R5 dec byte boundary", 4, 16'h0080, 16'h0001, 16'h007F, 1'b0, 6'b0);
    endtask

    task automatic t_shift();
        upd("R6 shr byte n=1", 6, 16'h0081, 16'h0001, 16'h0040, 1'b0, 6'b0);
        upd("R6 shr word n=16", 6, 16'h8000, 16'h0010, 16'h0000, 1'b1, 6'b0);
        upd("R6 shr byte beyond", 6, 16'h00FF, 16'h0009, 16'h0000, 1'b0, 6'b0);
        upd("R6 sar byte beyond", 7, 16'h0080, 16'h0009, 16'h00FF, 1'b0, 6'b0);
        upd("R6 sar word n=3", 7, 16'h8004, 16'h0003, 16'hF000, 1'b1, 6'b0);
        upd("R6 shl byte n=1", 5, 16'h00C0, 16'h0001, 16'h0080, 1'b0, 6'b0);
        upd("R6 shl word n=16", 5, 16'h0001, 16'h0010, 16'h0000, 1'b1, 6'b0);
        upd("R6 shl word beyond", 5, 16'hFFFF, 16'h0011, 16'h0000, 1'b1, 6'b0);
        upd("R8 shl overflow", 5, 16'h4000, 16'h0001, 16'h8000, 1'b1, 6'b0);
    endtask

    task automatic t_rotate();
        upd("R7 ror byte n=1", 9, 16'h0001, 16'h0001, 16'h0080, 1'b0, 6'b011110);
        upd("R7 ror byte n=9 wraps", 9, 16'h0001, 16'h0009, 16'h0080, 1'b0, 6'b000000);
        upd("R7 rol word n=1", 8, 16'h8000, 16'h0001, 16'h0001, 1'b1, 6'b010010);
        upd("R7 rol byte n=10", 8, 16'h0040, 16'h000A, 16'h0001, 1'b0, 6'b001100);
        upd("R8 ror word overflow", 9, 16'h0003, 16'h0001, 16'h8001, 1'b1, 6'b0);
    endtask

    task automatic t_load();
        ld_valid = 1'b1; ld_word = 16'h0AD5;
        step();
        exp_ctl = 3'b010;
        check("R9 load", 6'b111111);
        ld_valid = 1'b1; ld_word = 16'h0100;
        step();
        exp_ctl = 3'b001;
        check("R9 load clear", 6'b000000);
    endtask

    task automatic t_ctl();
        ctl_we = 3'b110; ctl_val = 3'b110;
        step();
        exp_ctl = 3'b111;
        check("R10 ctl write keeps arith", 6'b000000);
        ctl_we = 3'b001; ctl_val = 3'b000; ld_valid = 1'b1; ld_word = 16'h0FFF;
        step();
        exp_ctl = 3'b110;
        check("R10 ctl over load", 6'b111111);
    endtask

    task automatic t_collide();
        upd_valid = 1'b1; upd_op = 4'd1; upd_dst = 16'h0000; upd_src = 16'h0000;
        upd_res = 16'h0000; upd_word = 1'b1; upd_eflags = 6'b000001;
        ld_valid = 1'b1; ld_word = 16'h0881;
        step();
        exp_ctl = 3'b000;
        check("R11 load beats update", 6'b110001);
    endtask

    task automatic t_hold();
        upd("R13 setup", 2, 16'h0010, 16'h0001, 16'h000F, 1'b0, 6'b000001);
        upd_dst = 16'hFFFF; upd_res = 16'h1234; upd_op = 4'd0; ld_word = 16'h0000;
        repeat (3) @(negedge clk);
        check("R13 hold", ref_flags(2, 16'h0010, 16'h0001, 16'h000F, 1'b0, 6'b000001));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_eager();
        t_arith();
        t_shift();
        t_rotate();
        t_load();
        t_ctl();
        t_collide();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run ended=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule